// File: doc/BRIEF.md
# YCbCr 4:2:2 Byte-Lane Demultiplexer

This block sits at the front of a video encoder and turns an interleaved 4:2:2 YCbCr input into three aligned component streams. It accepts either a single byte lane that carries chroma and luma in turn on every clock, or two byte lanes where the low lane carries luma and the high lane carries chroma, loaded on alternate clocks. In both formats the chroma order within a pixel pair is Cb first, then Cr. Each luma sample leaves the block together with the Cb and Cr of its pair and a one-cycle valid strobe.

When embedded timing is enabled, the block watches the luma lane for timing references (an all-ones word, two all-zero words, then a flag word). It checks the flag word's protection bits, outputs the field, vertical-blank and horizontal flags, and only passes video between a start-of-line reference and the following end-of-line reference. Each start-of-line reference also resets the chroma phase, so a lost or extra byte corrupts no more than one line. Video words that hold the reserved extreme codes are clamped into the legal range.

Top module: `ycc_port_demux`

## Requirements
- R1: While `rstN` is low and on the first cycle after its release, `outValid`, `refStrobe`, `flagF`, `flagV`, `flagH`, `outY`, `outCb` and `outCr` are all zero.
- R2: With `wideMode` low, a word is taken from `pixLo` on every clock edge in the order Cb, Y0, Cr, Y1. After the edge that takes Cr, the outputs show (Y0, Cb, Cr) with `outValid` high. After the edge that takes Y1, they show (Y1, Cb, Cr) with `outValid` high. After the other two edges `outValid` is low.
- R3: With `wideMode` high, a load takes place on the first edge after reset and on every second edge after that. Each load takes luma from `pixLo` and chroma from `pixHi`, with the first load of a pair carrying Cb and Y0 and the second carrying Cr and Y1. After the second load the outputs show (Y0, Cb, Cr). After the next edge they show (Y1, Cb, Cr). Lane values on non-load edges have no effect.
- R4: A video word equal to 0 is output as 1, and a video word equal to all ones (255 at the default width) is output as all ones minus one (254). This applies to Y, Cb and Cr.
- R5: With `embSyncEn` high, the sequence all-ones, 0, 0, XY on the luma lane is a timing reference. Bit 7 of XY must be 1, bit 6 is F, bit 5 is V and bit 4 is H. After the edge that takes XY, `refStrobe` is high for one cycle and `flagF`/`flagV`/`flagH` hold F/V/H until the next accepted reference.
- R6: The low nibble of XY must equal {V^H, F^H, F^V, F^V^H}. If it does not, or if bit 7 is 0, the reference is ignored: no `refStrobe`, the flags are unchanged, and the line state is unchanged.
- R7: With `embSyncEn` high, `outValid` stays low until a reference with H=0 is accepted, and stays low again after a reference with H=1 is accepted. Reference words are never output as video.
- R8: An accepted reference with H=0 makes the next video word a Cb (and Y0 in the two-lane format), whatever chroma phase the previous line ended in.
- R9: With `embSyncEn` low, no reference is detected. All-ones and zero words are video and are only clamped, and `refStrobe` stays low.
- R10: If a preamble breaks before its flag word (all-ones followed by a non-zero word, or all-ones, 0 followed by a non-zero word), the words taken so far, including the breaking word, are dropped. No flags change and the chroma phase is not advanced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous active-low reset |
| wideMode | input | 1 | 0: one multiplexed lane; 1: luma lane plus chroma lane |
| embSyncEn | input | 1 | 1: detect embedded timing references and gate video by line |
| pixLo | input | W | Low lane: multiplexed data, or luma in the two-lane format |
| pixHi | input | W | High lane: Cb/Cr in the two-lane format, unused otherwise |
| outY | output | W | Luma sample |
| outCb | output | W | Cb of the sample's pair |
| outCr | output | W | Cr of the sample's pair |
| outValid | output | 1 | One-cycle strobe for each output sample |
| flagF | output | 1 | Field flag of the last accepted reference |
| flagV | output | 1 | Vertical-blank flag of the last accepted reference |
| flagH | output | 1 | H flag of the last accepted reference (1 = end of line) |
| refStrobe | output | 1 | Pulses for one cycle when a reference is accepted |

## Verification
The bench builds the block with the default word width of 8. This puts the flag word's fields at bits 7 to 0, so protection patterns and corrupted flag words can be built by hand. It also makes the extreme codes 0 and 255 frequent in random bytes, so clamping gets exercised often. Both lane formats are run with embedded timing off and on, resetting between configurations. In each configuration the bench mixes random pixel pairs with directed cases: broken preambles, bad protection bits, and a line that ends halfway through a pair.

// File: rtl/ycc_demux_pkg.sv
package ycc_demux_pkg;

  // Strobes from the sequencing control to the lane datapath.
  typedef struct packed {
    logic wide;    // two-lane format selected
    logic takeCb;  // capture chroma word as Cb
    logic takeY0;  // capture luma word as first sample of the pair
    logic takeCr;  // capture chroma word as Cr
    logic takeY1;  // capture luma word as second sample (two-lane only)
    logic emitA;   // output first sample of the pair
    logic emitB;   // output second sample of the pair
  } laneStrobe_t;

endpackage

// File: rtl/ycc_sync_ctrl.sv
module ycc_sync_ctrl
  import ycc_demux_pkg::*;
#(
  parameter int W = 8  // word width, at least 8; flag fields sit in the top 8 bits
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wideMode,
  input  logic         embSyncEn,
  input  logic [W-1:0] lumaWord,
  output laneStrobe_t  strb,
  output logic         flagF,
  output logic         flagV,
  output logic         flagH,
  output logic         refStrobe
);

  localparam logic [W-1:0] ALL_ONES = '1;
  localparam logic [W-1:0] ALL_ZERO = '0;

  typedef enum logic [1:0] {SEEK, GOT1, GOT2, GOT3} refState_t;

  refState_t  refSt;
  logic       loadTgl;
  logic       activeLine;
  logic [1:0] phase;
  logic       pendB;

  logic       acceptNow, inPreamble, lineOpen, isVideo, refHit, protOk;
  logic [7:0] xyTop;
  logic       xyF, xyV, xyH;

  always_comb begin
    acceptNow  = !wideMode || !loadTgl;
    inPreamble = embSyncEn && acceptNow && ((refSt != SEEK) || (lumaWord == ALL_ONES));
    lineOpen   = embSyncEn ? activeLine : 1'b1;
    isVideo    = acceptNow && lineOpen && !inPreamble;

    xyTop  = lumaWord[W-1 -: 8];
    xyF    = xyTop[6];
    xyV    = xyTop[5];
    xyH    = xyTop[4];
    protOk = xyTop[7] && (xyTop[3:0] == {xyV ^ xyH, xyF ^ xyH, xyF ^ xyV, xyF ^ xyV ^ xyH});
    refHit = embSyncEn && acceptNow && (refSt == GOT3) && protOk;
  end

  always_comb begin
    strb      = '0;
    strb.wide = wideMode;
    if (wideMode) begin
      strb.takeCb = isVideo && !phase[0];
      strb.takeY0 = isVideo && !phase[0];
      strb.takeCr = isVideo && phase[0];
      strb.takeY1 = isVideo && phase[0];
      strb.emitA  = isVideo && phase[0];
      strb.emitB  = pendB;
    end else begin
      strb.takeCb = isVideo && (phase == 2'd0);
      strb.takeY0 = isVideo && (phase == 2'd1);
      strb.takeCr = isVideo && (phase == 2'd2);
      strb.emitA  = isVideo && (phase == 2'd2);
      strb.emitB  = isVideo && (phase == 2'd3);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadTgl    <= 1'b0;
      refSt      <= SEEK;
      activeLine <= 1'b0;
      phase      <= 2'd0;
      pendB      <= 1'b0;
      flagF      <= 1'b0;
      flagV      <= 1'b0;
      flagH      <= 1'b0;
      refStrobe  <= 1'b0;
    end else begin
      loadTgl   <= ~loadTgl;
      pendB     <= wideMode && isVideo && phase[0];
      refStrobe <= refHit;

      if (!embSyncEn) begin
        refSt <= SEEK;
      end else if (acceptNow) begin
        case (refSt)
          SEEK:    refSt <= (lumaWord == ALL_ONES) ? GOT1 : SEEK;
          GOT1:    refSt <= (lumaWord == ALL_ZERO) ? GOT2 : SEEK;
          GOT2:    refSt <= (lumaWord == ALL_ZERO) ? GOT3 : SEEK;
          default: refSt <= SEEK;
        endcase
      end

      if (refHit) begin
        activeLine <= !xyH;
        flagF      <= xyF;
        flagV      <= xyV;
        flagH      <= xyH;
      end

      if (refHit && !xyH)
        phase <= 2'd0;
      else if (isVideo)
        phase <= wideMode ? {1'b0, ~phase[0]} : phase + 2'd1;
    end
  end

  // R5: flags only move together with the reference strobe
  a_r5_flags_move_with_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({flagF, flagV, flagH}) |-> refStrobe);

  // R9: no preamble tracking unless embedded timing was enabled
  a_r9_no_preamble_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (refSt != SEEK) |-> $past(embSyncEn));

  // R9: no reference strobe unless embedded timing was enabled
  a_r9_no_strobe_when_off: assert property (@(posedge clk) disable iff (!rstN)
    refStrobe |-> $past(embSyncEn));

endmodule

// File: rtl/ycc_lane_path.sv
module ycc_lane_path
  import ycc_demux_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  laneStrobe_t  strb,
  input  logic [W-1:0] loWord,
  input  logic [W-1:0] hiWord,
  output logic [W-1:0] outY,
  output logic [W-1:0] outCb,
  output logic [W-1:0] outCr,
  output logic         outValid
);

  localparam logic [W-1:0] CODE_MAX = '1;
  localparam logic [W-1:0] CODE_MIN = '0;
  localparam logic [W-1:0] LEGAL_HI = CODE_MAX - 1'b1;
  localparam logic [W-1:0] LEGAL_LO = CODE_MIN + 1'b1;

  function automatic logic [W-1:0] clampCode(input logic [W-1:0] v);
    if (v == CODE_MAX) return LEGAL_HI;
    if (v == CODE_MIN) return LEGAL_LO;
    return v;
  endfunction

  logic [W-1:0] lumaIn, chromaIn;
  logic [W-1:0] cbReg, crReg, y0Reg, y1Reg;

  always_comb begin
    lumaIn   = clampCode(loWord);
    chromaIn = clampCode(strb.wide ? hiWord : loWord);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cbReg    <= '0;
      crReg    <= '0;
      y0Reg    <= '0;
      y1Reg    <= '0;
      outY     <= '0;
      outCb    <= '0;
      outCr    <= '0;
      outValid <= 1'b0;
    end else begin
      if (strb.takeCb) cbReg <= chromaIn;
      if (strb.takeCr) crReg <= chromaIn;
      if (strb.takeY0) y0Reg <= lumaIn;
      if (strb.takeY1) y1Reg <= lumaIn;
      outValid <= strb.emitA || strb.emitB;
      if (strb.emitA) begin
        outY  <= y0Reg;
        outCb <= cbReg;
        outCr <= chromaIn;
      end else if (strb.emitB) begin
        outY  <= strb.wide ? y1Reg : lumaIn;
        outCb <= cbReg;
        outCr <= crReg;
      end
    end
  end

  // R4: extreme codes never leave the block
  a_r4_luma_clamped: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outY != CODE_MAX) && (outY != CODE_MIN));
  a_r4_chroma_clamped: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outCb != CODE_MAX) && (outCb != CODE_MIN) && (outCr != CODE_MAX) && (outCr != CODE_MIN));

  // R3: in the two-lane format the second sample directly follows the first
  a_r3_second_follows_first: assert property (@(posedge clk) disable iff (!rstN)
    (strb.emitB && strb.wide) |-> $past(strb.emitA));

endmodule

// File: rtl/ycc_port_demux.sv
module ycc_port_demux
  import ycc_demux_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wideMode,
  input  logic         embSyncEn,
  input  logic [W-1:0] pixLo,
  input  logic [W-1:0] pixHi,
  output logic [W-1:0] outY,
  output logic [W-1:0] outCb,
  output logic [W-1:0] outCr,
  output logic         outValid,
  output logic         flagF,
  output logic         flagV,
  output logic         flagH,
  output logic         refStrobe
);

  laneStrobe_t strb;

  ycc_sync_ctrl #(.W(W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wideMode  (wideMode),
    .embSyncEn (embSyncEn),
    .lumaWord  (pixLo),
    .strb      (strb),
    .flagF     (flagF),
    .flagV     (flagV),
    .flagH     (flagH),
    .refStrobe (refStrobe)
  );

  ycc_lane_path #(.W(W)) i_path (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .loWord   (pixLo),
    .hiWord   (pixHi),
    .outY     (outY),
    .outCb    (outCb),
    .outCr    (outCr),
    .outValid (outValid)
  );

  // R1: nothing is flagged valid on the first cycle out of reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rstN) |-> !outValid && !refStrobe);

endmodule

// File: tb/test_ycc_port_demux.sv
module test_ycc_port_demux;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wideMode = 1'b0;
  logic       embSyncEn = 1'b0;
  logic [7:0] pixLo = '0;
  logic [7:0] pixHi = '0;
  logic [7:0] outY, outCb, outCr;
  logic       outValid, flagF, flagV, flagH, refStrobe;

  int checks = 0;
  int failures = 0;
  int expF = 0, expV = 0, expH = 0;

  always #4 clk = ~clk;

  ycc_port_demux i_ycc_port_demux (
    .clk(clk), .rstN(rstN), .wideMode(wideMode), .embSyncEn(embSyncEn),
    .pixLo(pixLo), .pixHi(pixHi), .outY(outY), .outCb(outCb), .outCr(outCr),
    .outValid(outValid), .flagF(flagF), .flagV(flagV), .flagH(flagH),
    .refStrobe(refStrobe)
  );

  function automatic int clampB(input int b);
    if (b == 255) return 254;
    if (b == 0) return 1;
    return b;
  endfunction

  function automatic int mkXY(input int f, input int v, input int h);
    return 128 + f * 64 + v * 32 + h * 16 + (v ^ h) * 8 + (f ^ h) * 4 + (f ^ v) * 2 + (f ^ v ^ h);
  endfunction

  task automatic chkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int lo, input int hi = 0);
    pixLo = 8'(lo);
    pixHi = 8'(hi);
    @(posedge clk);
    #1;
  endtask

  task automatic doReset(input bit wide, input bit sync);
    rstN = 1'b0;
    wideMode = wide;
    embSyncEn = sync;
    pixLo = '0;
    pixHi = '0;
    repeat (3) @(posedge clk);
    #1;
    chkEq("R1 valid in reset", outValid, 0);
    chkEq("R1 Y in reset", outY, 0);
    rstN = 1'b1;
    expF = 0; expV = 0; expH = 0;
  endtask

  task automatic expVid(input string req, input int y, input int cb, input int cr);
    chkEq({req, " valid"}, outValid, 1);
    chkEq({req, " Y"}, outY, y);
    chkEq({req, " Cb"}, outCb, cb);
    chkEq({req, " Cr"}, outCr, cr);
  endtask

  task automatic send8(input string req, input int cb, input int y0, input int cr, input int y1);
    step(cb);
    chkEq({req, " no sample after Cb"}, outValid, 0);
    step(y0);
    chkEq({req, " no sample after Y0"}, outValid, 0);
    step(cr);
    expVid({req, " first"}, clampB(y0), clampB(cb), clampB(cr));
    step(y1);
    expVid({req, " second"}, clampB(y1), clampB(cb), clampB(cr));
  endtask

  task automatic send16(input string req, input int cb, input int y0, input int cr, input int y1);
    step(y0, cb);
    chkEq({req, " no sample after first load"}, outValid, 0);
    step($urandom % 256, $urandom % 256);
    chkEq({req, " no sample on idle edge"}, outValid, 0);
    step(y1, cr);
    expVid({req, " first"}, clampB(y0), clampB(cb), clampB(cr));
    step($urandom % 256, $urandom % 256);
    expVid({req, " second"}, clampB(y1), clampB(cb), clampB(cr));
  endtask

  task automatic checkFlags(input string req);
    chkEq({req, " F"}, flagF, expF);
    chkEq({req, " V"}, flagV, expV);
    chkEq({req, " H"}, flagH, expH);
  endtask

  // one-lane reference; badMask flips bits of the flag word
  task automatic sendRef8(input int f, input int v, input int h, input int badMask);
    step(255);
    chkEq("R7 preamble word not video", outValid, 0);
    step(0);
    step(0);
    step(mkXY(f, v, h) ^ badMask);
    chkEq("R7 flag word not video", outValid, 0);
    if (badMask == 0) begin
      expF = f; expV = v; expH = h;
      chkEq("R5 strobe on reference", refStrobe, 1);
      checkFlags("R5 flags");
    end else begin
      chkEq("R6 no strobe on bad protection", refStrobe, 0);
      checkFlags("R6 flags kept");
    end
  endtask

  task automatic sendRef16(input int f, input int v, input int h);
    step(255, 255);
    step(7, 7);
    step(0, 255);
    step(7, 7);
    step(0, 0);
    step(7, 7);
    step(mkXY(f, v, h), 255);
    expF = f; expV = v; expH = h;
    chkEq("R5 two-lane strobe", refStrobe, 1);
    checkFlags("R5 two-lane flags");
    step(9, 9);
    chkEq("R7 two-lane reference not video", outValid, 0);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unsigned seedSet;
    seedSet = $urandom(32'd20231);

    // ---------------- one lane, no embedded timing ----------------
    doReset(0, 0);
    chkEq("R1 valid after reset", outValid, 0);
    chkEq("R1 strobe after reset", refStrobe, 0);
    chkEq("R1 Cb after reset", outCb, 0);
    chkEq("R1 Cr after reset", outCr, 0);
    checkFlags("R1 flags after reset");
    send8("R2 directed", 90, 16, 200, 235);
    send8("R4 extremes", 255, 0, 0, 255);
    // R9: a would-be reference is plain video here
    send8("R9 preamble as video", 255, 0, 0, mkXY(0, 0, 0));
    chkEq("R9 no strobe", refStrobe, 0);
    checkFlags("R9 flags untouched");
    for (int i = 0; i < 300; i++)
      send8("R2 random", $urandom % 256, $urandom % 256, $urandom % 256, $urandom % 256);

    // ---------------- two lanes, no embedded timing ----------------
    doReset(1, 0);
    send16("R3 directed", 60, 20, 180, 40);
    send16("R4 two-lane extremes", 255, 0, 0, 255);
    for (int i = 0; i < 200; i++)
      send16("R3 random", $urandom % 256, $urandom % 256, $urandom % 256, $urandom % 256);

    // ---------------- one lane, embedded timing ----------------
    doReset(0, 1);
    step(10); chkEq("R7 closed before first start", outValid, 0);
    step(20); chkEq("R7 closed before first start", outValid, 0);
    step(30); chkEq("R7 closed before first start", outValid, 0);
    step(40); chkEq("R7 closed before first start", outValid, 0);
    sendRef8(1, 1, 0, 0);
    send8("R7 open line", 0, 16, 128, 200);
    // R8: line ends halfway through a pair
    step(50);
    step(60);
    sendRef8(1, 1, 1, 0);
    step(70); chkEq("R7 closed after end", outValid, 0);
    step(80); chkEq("R7 closed after end", outValid, 0);
    sendRef8(0, 0, 0, 0);
    send8("R8 realigned", 11, 22, 33, 44);
    // R6: corrupted end reference leaves the line open
    sendRef8(0, 0, 1, 1);
    send8("R6 line still open", 101, 102, 103, 104);
    sendRef8(0, 0, 1, 128);
    send8("R6 bit7 clear ignored", 111, 112, 113, 114);
    // R10: broken preambles
    step(255); step(5);
    chkEq("R10 no strobe", refStrobe, 0);
    step(255); step(0); step(6);
    chkEq("R10 no strobe", refStrobe, 0);
    checkFlags("R10 flags kept");
    send8("R10 phase kept", 120, 121, 122, 123);
    for (int ln = 0; ln < 20; ln++) begin
      int f = $urandom % 2;
      int v = $urandom % 2;
      sendRef8(f, v, 0, 0);
      for (int q = 0; q < 6; q++)
        send8("R5 random line", $urandom % 255, $urandom % 255, $urandom % 255, $urandom % 255);
      sendRef8(f, v, 1, 0);
      step(33); chkEq("R7 random blank", outValid, 0);
    end

    // ---------------- two lanes, embedded timing ----------------
    doReset(1, 1);
    step(50, 60); chkEq("R7 two-lane closed", outValid, 0);
    step(50, 60); chkEq("R7 two-lane closed", outValid, 0);
    step(70, 80); chkEq("R7 two-lane closed", outValid, 0);
    step(70, 80); chkEq("R7 two-lane closed", outValid, 0);
    sendRef16(0, 0, 0);
    send16("R3 two-lane open", 255, 16, 0, 235);
    // half a pair, then end and restart the line
    step(40, 41); step(1, 2);
    sendRef16(1, 0, 1);
    sendRef16(1, 0, 0);
    send16("R8 two-lane realigned", 70, 71, 72, 73);
    for (int q = 0; q < 30; q++)
      send16("R3 two-lane random", $urandom % 256, $urandom % 255, $urandom % 256, $urandom % 255);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule